// File: doc/BRIEF.md
# Memory-Mapped Write to Packet Stream FIFO

This block accepts 32-bit writes from a memory-mapped host and turns them into beats on a packet-streaming source port. The host sees two word locations. The data word at address 0 carries four 8-bit symbols. The status word at address 1 carries the packet sideband: the start and end markers, the count of unused symbols in a final beat, a channel number and an error code. Only a write to the data word creates a beat. That write stores the symbols in a FIFO together with a snapshot of the sideband held at that moment.

The sideband stays in its register from one beat to the next. A host therefore writes the status word when a packet starts, when channel or error changes, and just before the last beat, where it sets the end marker and the unused-symbol count. The start marker clears itself once the first beat has been stored. The end marker clears itself once the beat that carries it has been stored. The symbol order is reversed on the way through: the lowest symbol of the memory word leaves first, in the top byte of the stream word.

Options are set by parameters. When backpressure is enabled, a data write made while the FIFO is full is stalled through `wr_wait`. When packet mode is off, the status word is ignored and the sideband outputs stay at zero.

Top module: `mmwr_stream_fifo`

## Requirements
- R1: A write with `wr_addr`=0 that is not stalled stores one beat. `src_valid` is high from the next clock edge. `src_data` is the written word with its symbols reversed: write bits [7:0] appear on [31:24], [15:8] on [23:16], [23:16] on [15:8] and [31:24] on [7:0].
- R2: A write with `wr_addr`=1 never stores a beat. `src_valid` stays low if the FIFO was empty, and the fill level does not change.
- R3: Field positions in the status word are as follows. Start is bit 0 and end is bit 1. The unused-symbol count is taken from the low 2 bits of the field at bits [6:2], so bits [6:4] are ignored. Channel is bits [15:8] and error is bits [23:16]. Bit 7 and bits [31:24] are ignored.
- R4: Each stored beat carries the held channel, error and unused-symbol count. These values persist across any number of data writes until the next status write.
- R5: Once a beat has been stored, the start and end markers read 0 for later beats unless the status word is written again.
- R6: With backpressure on, `wr_wait` is high during a data write while the FIFO holds DEPTH entries, and the write takes effect in the first cycle that `wr_wait` is low. A status write never raises `wr_wait`. The fill level never exceeds DEPTH.
- R7: Beats leave in write order, one per cycle in which `src_valid` and `src_ready` are both high. `src_valid` is high exactly while the FIFO is non-empty. While `src_ready` is low, the presented beat holds steady.
- R8: With packet mode off, status writes have no effect and `src_sop`, `src_eop`, `src_empty`, `src_channel` and `src_error` are 0 on every beat. Data handling is unchanged.
- R9: After reset the FIFO is empty, `wr_wait` is low and the held sideband is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 1 | Word select: 0 data, 1 status |
| wr_data | input | 32 | Write data |
| wr_wait | output | 1 | Stall for the current write |
| src_valid | output | 1 | Beat available |
| src_ready | input | 1 | Sink accepts beat |
| src_data | output | 32 | Beat symbols, first symbol in the top byte |
| src_sop | output | 1 | Start of packet |
| src_eop | output | 1 | End of packet |
| src_empty | output | 2 | Unused symbols in the beat |
| src_channel | output | 8 | Channel number |
| src_error | output | 8 | Error code |

## Verification
`wr_wait` is combinational on the current write and the fill level, so the bench checks it 1 ns after it drives a write, before the edge that would take that write. A stored beat reaches the source outputs one edge after the write: one register stage, with a combinational read of the FIFO head. The bench therefore drives at a falling edge and compares the outputs at the next falling edge. With `src_ready` held high, each beat is removed at the edge that follows, so every table row is checked in exactly one window. The stall sequence counts the cycles explicitly. The bench checks that the stalled write does not land at the edge where a pop frees a slot. It lands one edge later, and the checks expect that.

// File: rtl/mmwf_pkg.sv
package mmwf_pkg;
   // Word select values on the write port
   localparam logic SEL_DATA = 1'b0;
   localparam logic SEL_STAT = 1'b1;

   // Status word field positions (decoded by the status register)
   localparam int POS_SOP   = 0;
   localparam int POS_EOP   = 1;
   localparam int POS_EMPTY = 2;
   localparam int POS_CHAN  = 8;
   localparam int POS_ERR   = 16;

   // Room reserved for each variable-width field
   localparam int ROOM_EMPTY = 5;
   localparam int ROOM_CHAN  = 8;
   localparam int ROOM_ERR   = 8;

   localparam int BUS_W = 32;
endpackage

// File: rtl/mmwf_status_reg.sv
module mmwf_status_reg
   import mmwf_pkg::*;
#(
   parameter int EMPTY_W   = 2,
   parameter int CHAN_W    = 8,
   parameter int ERR_W     = 8,
   parameter bit PACKET_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stat_we,
   input  logic [BUS_W-1:0]   stat_data,
   input  logic               push,
   output logic               held_sop,
   output logic               held_eop,
   output logic [EMPTY_W-1:0] held_empty,
   output logic [CHAN_W-1:0]  held_chan,
   output logic [ERR_W-1:0]   held_err
);
   logic unused_stat;
   assign unused_stat = ^{stat_data, stat_we, push};

   if (EMPTY_W > ROOM_EMPTY) begin : g_bad_empty
      $error("EMPTY_W exceeds its field");
   end
   if (CHAN_W > ROOM_CHAN) begin : g_bad_chan
      $error("CHAN_W exceeds its field");
   end
   if (ERR_W > ROOM_ERR) begin : g_bad_err
      $error("ERR_W exceeds its field");
   end

   if (PACKET_EN) begin : g_pkt
      logic               sop_q, eop_q;
      logic [EMPTY_W-1:0] empty_q;
      logic [CHAN_W-1:0]  chan_q;
      logic [ERR_W-1:0]   err_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sop_q   <= 1'b0;
            eop_q   <= 1'b0;
            empty_q <= '0;
            chan_q  <= '0;
            err_q   <= '0;
         end else if (stat_we) begin
            sop_q   <= stat_data[POS_SOP];
            eop_q   <= stat_data[POS_EOP];
            empty_q <= stat_data[POS_EMPTY +: EMPTY_W];
            chan_q  <= stat_data[POS_CHAN +: CHAN_W];
            err_q   <= stat_data[POS_ERR +: ERR_W];
         end else if (push) begin
            // markers are one-shot; the rest stays for later beats
            sop_q <= 1'b0;
            eop_q <= 1'b0;
         end
      end

      assign held_sop   = sop_q;
      assign held_eop   = eop_q;
      assign held_empty = empty_q;
      assign held_chan  = chan_q;
      assign held_err   = err_q;
   end else begin : g_raw
      assign held_sop   = 1'b0;
      assign held_eop   = 1'b0;
      assign held_empty = '0;
      assign held_chan  = '0;
      assign held_err   = '0;
   end
endmodule

// File: rtl/mmwf_sym_swap.sv
module mmwf_sym_swap #(
   parameter int DATA_W = 32,
   parameter int SYM_W  = 8
) (
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] word_out
);
   localparam int SYMS = DATA_W / SYM_W;

   if (DATA_W % SYM_W != 0) begin : g_bad_sym
      $error("DATA_W must be a multiple of SYM_W");
   end

   for (genvar i = 0; i < SYMS; i++) begin : g_sym
      assign word_out[(SYMS-1-i)*SYM_W +: SYM_W] = word_in[i*SYM_W +: SYM_W];
   end
endmodule

// File: rtl/mmwf_fifo.sv
module mmwf_fifo #(
   parameter int WIDTH = 52,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] fill
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];
   assign fill    = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/mmwr_stream_fifo.sv
module mmwr_stream_fifo
   import mmwf_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int SYM_W           = 8,
   parameter int CHAN_W          = 8,
   parameter int ERR_W           = 8,
   parameter int DEPTH           = 16,
   parameter bit PACKET_EN       = 1'b1,
   parameter bit BACKPRESSURE_EN = 1'b1,
   localparam int SYMS    = DATA_W / SYM_W,
   localparam int EMPTY_W = (SYMS > 1) ? $clog2(SYMS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               wr_wait,
   output logic               src_valid,
   input  logic               src_ready,
   output logic [DATA_W-1:0]  src_data,
   output logic               src_sop,
   output logic               src_eop,
   output logic [EMPTY_W-1:0] src_empty,
   output logic [CHAN_W-1:0]  src_channel,
   output logic [ERR_W-1:0]   src_error
);
   localparam int ENT_W = 2 + EMPTY_W + CHAN_W + ERR_W + DATA_W;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DATA_W != BUS_W) begin : g_bad_bus
      $error("DATA_W must match the 32-bit write bus");
   end

   logic               data_we, stat_we, push, pop, full, empty;
   logic               held_sop, held_eop;
   logic [EMPTY_W-1:0] held_empty;
   logic [CHAN_W-1:0]  held_chan;
   logic [ERR_W-1:0]   held_err;
   logic [DATA_W-1:0]  swapped;
   logic [ENT_W-1:0]   ent_in, ent_out;
   logic [CNT_W-1:0]   fill_cnt;

   assign data_we = wr_en && (wr_addr == SEL_DATA);
   assign stat_we = wr_en && (wr_addr == SEL_STAT);

   if (BACKPRESSURE_EN) begin : g_bp
      assign wr_wait = data_we && full;
   end else begin : g_nobp
      assign wr_wait = 1'b0;   // writes into a full FIFO are dropped
   end
   assign push = data_we && !full;
   assign pop  = src_valid && src_ready;

   mmwf_status_reg #(
      .EMPTY_W(EMPTY_W), .CHAN_W(CHAN_W), .ERR_W(ERR_W), .PACKET_EN(PACKET_EN)
   ) stat_i (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_data(wr_data),
      .push(push), .held_sop(held_sop), .held_eop(held_eop),
      .held_empty(held_empty), .held_chan(held_chan), .held_err(held_err)
   );

   mmwf_sym_swap #(.DATA_W(DATA_W), .SYM_W(SYM_W)) swap_i (
      .word_in(wr_data), .word_out(swapped)
   );

   assign ent_in = {held_sop, held_eop, held_empty, held_chan, held_err, swapped};

   mmwf_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push), .din(ent_in), .pop(pop),
      .dout(ent_out), .full(full), .empty(empty), .fill(fill_cnt)
   );

   assign src_valid = !empty;
   assign {src_sop, src_eop, src_empty, src_channel, src_error, src_data} = ent_out;
endmodule

// File: rtl/mmwr_stream_fifo_chk.sv
module mmwr_stream_fifo_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic              wr_wait,
   input logic              src_valid,
   input logic              src_ready,
   input logic [DATA_W-1:0] src_data,
   input logic [CNT_W-1:0]  fill,
   input logic              push,
   input logic              held_sop,
   input logic              held_eop
);
   AST_STAT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |-> !wr_wait);                                    // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));                                              // R6
   AST_STAT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && !(src_valid && src_ready)) |=> $stable(fill));  // R2
   AST_DATA_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && !wr_wait && fill != CNT_W'(DEPTH)
       && !(src_valid && src_ready)) |=> fill == $past(fill) + 1'b1);      // R1
   AST_MARK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (!held_sop && !held_eop));                                  // R5
   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && !src_ready) |=> (src_valid && $stable(src_data)));     // R7
endmodule

bind mmwr_stream_fifo mmwr_stream_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wait(wr_wait),
   .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
   .fill(fill_cnt), .push(push), .held_sop(held_sop), .held_eop(held_eop)
);

// File: tb/mmwr_stream_fifo_tb_top.sv
module mmwr_stream_fifo_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   typedef struct packed {
      logic        addr;
      logic [31:0] wd;
      logic        ev;
      logic [31:0] ed;
      logic        es;
      logic        ee;
      logic [1:0]  em;
      logic [7:0]  ec;
      logic [7:0]  er;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'hDDCC_BBAA, 1'b1, 32'hAABB_CCDD, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
      '{1'b1, 32'hAB00_05F1, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
      '{1'b0, 32'h4433_2211, 1'b1, 32'h1122_3344, 1'b1, 1'b0, 2'd0, 8'h05, 8'h00},
      '{1'b0, 32'h8877_6655, 1'b1, 32'h5566_7788, 1'b0, 1'b0, 2'd0, 8'h05, 8'h00},
      '{1'b1, 32'h003C_0506, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
      '{1'b0, 32'hCCBB_AA99, 1'b1, 32'h99AA_BBCC, 1'b0, 1'b1, 2'd1, 8'h05, 8'h3C},
      '{1'b0, 32'h0000_00EE, 1'b1, 32'hEE00_0000, 1'b0, 1'b0, 2'd1, 8'h05, 8'h3C},
      '{1'b1, 32'h0000_0701, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
      '{1'b0, 32'h0403_0201, 1'b1, 32'h0102_0304, 1'b1, 1'b0, 2'd0, 8'h07, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        src_ready = 1'b0;
   logic        wr_wait, src_valid, src_sop, src_eop;
   logic [31:0] src_data;
   logic [1:0]  src_empty;
   logic [7:0]  src_channel, src_error;
   logic        r_wait, r_valid, r_sop, r_eop;
   logic [31:0] r_data;
   logic [1:0]  r_empty;
   logic [7:0]  r_channel, r_error;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmwr_stream_fifo #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_wait(wr_wait), .src_valid(src_valid), .src_ready(src_ready),
      .src_data(src_data), .src_sop(src_sop), .src_eop(src_eop),
      .src_empty(src_empty), .src_channel(src_channel), .src_error(src_error)
   );

   mmwr_stream_fifo #(.DEPTH(DEPTH), .PACKET_EN(1'b0)) raw_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_wait(r_wait), .src_valid(r_valid), .src_ready(src_ready),
      .src_data(r_data), .src_sop(r_sop), .src_eop(r_eop),
      .src_empty(r_empty), .src_channel(r_channel), .src_error(r_error)
   );

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [31:0] fw(input int i);
      return 32'hA0B0_C000 | 32'(i);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9", "valid in reset", 32'(src_valid), 32'd0);
      chk("R9", "wait in reset", 32'(wr_wait), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "valid after reset", 32'(src_valid), 32'd0);
      chk("R9", "wait after reset", 32'(wr_wait), 32'd0);

      // table walk: one write per cycle, sink always ready
      src_ready = 1'b1;
      for (int v = 0; v < NV; v++) begin
         wr_en   = 1'b1;
         wr_addr = VEC[v].addr;
         wr_data = VEC[v].wd;
         @(negedge clk);
         wr_en = 1'b0;
         chk("R2", $sformatf("v%0d valid", v), 32'(src_valid), 32'(VEC[v].ev));
         chk("R8", $sformatf("v%0d raw valid", v), 32'(r_valid), 32'(VEC[v].ev));
         if (VEC[v].ev) begin
            chk("R1", $sformatf("v%0d data", v), src_data, VEC[v].ed);
            chk("R5", $sformatf("v%0d sop", v), 32'(src_sop), 32'(VEC[v].es));
            chk("R5", $sformatf("v%0d eop", v), 32'(src_eop), 32'(VEC[v].ee));
            chk("R3", $sformatf("v%0d empty", v), 32'(src_empty), 32'(VEC[v].em));
            chk("R4", $sformatf("v%0d channel", v), 32'(src_channel), 32'(VEC[v].ec));
            chk("R4", $sformatf("v%0d error", v), 32'(src_error), 32'(VEC[v].er));
            chk("R8", $sformatf("v%0d raw data", v), r_data, VEC[v].ed);
            chk("R8", $sformatf("v%0d raw side", v),
                32'({r_sop, r_eop, r_empty, r_channel, r_error}), 32'd0);
         end
      end
      @(negedge clk);
      chk("R7", "drained", 32'(src_valid), 32'd0);

      // R6: fill with sink stalled
      src_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         wr_en = 1'b1; wr_addr = 1'b0; wr_data = fw(i);
         #1 chk("R6", $sformatf("no wait fill %0d", i), 32'(wr_wait), 32'd0);
         @(negedge clk);
      end
      wr_addr = 1'b1; wr_data = 32'h0;
      #1 chk("R6", "status write when full", 32'(wr_wait), 32'd0);
      @(negedge clk);
      wr_addr = 1'b0; wr_data = 32'h1234_5678;
      #1 chk("R6", "wait when full", 32'(wr_wait), 32'd1);
      chk("R7", "head beat", src_data, rev(fw(0)));
      @(negedge clk);
      chk("R6", "still waiting", 32'(wr_wait), 32'd1);
      chk("R7", "head held", src_data, rev(fw(0)));
      src_ready = 1'b1;
      @(negedge clk);
      chk("R6", "wait drops after pop", 32'(wr_wait), 32'd0);
      chk("R7", "second beat", src_data, rev(fw(1)));
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7", "third beat", src_data, rev(fw(2)));
      for (int i = 3; i < DEPTH; i++) begin
         @(negedge clk);
         chk("R7", $sformatf("beat %0d", i), src_data, rev(fw(i)));
      end
      @(negedge clk);
      chk("R6", "held write landed", src_data, rev(32'h1234_5678));
      chk("R7", "last valid", 32'(src_valid), 32'd1);
      @(negedge clk);
      chk("R7", "empty after drain", 32'(src_valid), 32'd0);
      finish_run();
   end
endmodule